// File: doc/BRIEF.md
# Serial Boot Escape Responder

This block sits behind a UART byte interface and talks a small boot protocol with a host. It starts out asleep. While asleep it accepts and drops every received byte until an escape byte (0x1B) arrives. Each escape is answered with one acknowledge byte (0x06), and the block wakes up.

Once awake, the block collects request packets. A packet is a 16-bit opcode, a 16-bit length, that many payload bytes, and a closing checksum byte. The block checks the checksum and dispatches on the opcode. A version query returns the version numbers and the largest packet length the block accepts. Any other request, including one with a bad checksum, is answered with a negative acknowledge that echoes the opcode.

A wait counter, stepped by a prescaler tick, ends the session when no bytes arrive for too long. If a request was cut short, the block still sends a reply before it goes back to sleep, so the host never waits forever.

Top module: `boot_escape_responder`

## Requirements
- R1: Every accepted byte 0x1B produces exactly one byte 0x06 on the transmit side, offered in the cycle after the accepting edge; a burst of N escapes yields N acknowledges.
- R2: While asleep (after reset or after a timeout), non-escape bytes are accepted and dropped with no reply.
- R3: A packet is opcode high, opcode low, length high, length low, length payload bytes, then a checksum byte chosen so the 8-bit sum of all packet bytes is zero; the first reply byte is offered in the cycle after the checksum byte is accepted.
- R4: A packet with good checksum and opcode 0x0000 is answered with 0x15, 0x00, 0x00.
- R5: A packet with good checksum, opcode 0x0002 and length no larger than MAX_PKT_LEN is answered with 0x06, VER_MAJOR, VER_MINOR, MAX_PKT_LEN high byte, MAX_PKT_LEN low byte.
- R6: A packet whose checksum does not sum to zero is still answered, with 0x15 followed by the received opcode high and low bytes.
- R7: A good packet with any other opcode, or opcode 0x0002 with length above MAX_PKT_LEN, is answered with 0x15 and the echoed opcode.
- R8: An escape byte in the middle of a packet discards the partial packet, draws an acknowledge, and the next byte starts a new packet.
- R9: Each escape loads the wait counter with WAIT_LOAD. At every prescaler tick (every TICK_DIV cycles) the counter reloads if bytes have arrived since the previous tick and decrements otherwise. When it reaches zero, timed_out goes high and the block falls asleep.
- R10: If the wait counter expires with a partial packet, the block sends 0x15 with the opcode collected so far (missing bytes as 0x00) before sleeping.
- R11: A reply byte stays offered and unchanged while tx_ready is low, and rx_ready is low while a reply is pending.
- R12: timed_out stays high until the next escape byte is accepted, and falls on that edge.
- R13: After reset the block is asleep, with tx_valid low, rx_ready high and timed_out low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Block can take a received byte |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | Transmit byte present |
| tx_ready | input | 1 | Serialiser takes the transmit byte |
| timed_out | output | 1 | Session ended by the wait counter |

## Verification
An acknowledge to an escape, and the first byte of any packet reply, is due exactly one cycle after the accepting edge. The bench drives and samples at falling edges and checks tx_valid and tx_data at the first falling edge after acceptance. Later reply bytes are gathered by a monitor on each transfer and compared in order once the reply has drained. A timeout can only be placed within a window of about two prescaler ticks, so the bench checks that timed_out is still low well before the earliest expiry and already high after the latest one.

// File: rtl/esc_pkg.sv
package esc_pkg;
  localparam logic [7:0] BYTE_ESC = 8'h1B;
  localparam logic [7:0] BYTE_ACK = 8'h06;
  localparam logic [7:0] BYTE_NAK = 8'h15;
  localparam logic [15:0] OP_NULL = 16'h0000;
  localparam logic [15:0] OP_VER  = 16'h0002;
  localparam int REPLY_MAX = 5;
  localparam int REPLY_NW  = $clog2(REPLY_MAX + 1);

  typedef enum logic [2:0] {
    PH_OPH, PH_OPL, PH_LNH, PH_LNL, PH_PAY, PH_CHK
  } phase_t;

  typedef enum logic {ST_ASLEEP, ST_AWAKE} sess_t;

  typedef struct packed {
    logic [REPLY_NW-1:0]              n;
    logic [REPLY_MAX-1:0][7:0]        b;
  } reply_t;

  function automatic logic [7:0] sum8(input logic [7:0] a, input logic [7:0] c);
    return a + c;
  endfunction

  function automatic reply_t mk_ack();
    reply_t r;
    r = '0;
    r.n = REPLY_NW'(1);
    r.b[0] = BYTE_ACK;
    return r;
  endfunction

  function automatic reply_t mk_nak(input logic [15:0] op);
    reply_t r;
    r = '0;
    r.n = REPLY_NW'(3);
    r.b[0] = BYTE_NAK;
    r.b[1] = op[15:8];
    r.b[2] = op[7:0];
    return r;
  endfunction

  function automatic reply_t mk_ver(input logic [7:0] maj, input logic [7:0] mnr,
                                    input logic [15:0] maxlen);
    reply_t r;
    r = '0;
    r.n = REPLY_NW'(5);
    r.b[0] = BYTE_ACK;
    r.b[1] = maj;
    r.b[2] = mnr;
    r.b[3] = maxlen[15:8];
    r.b[4] = maxlen[7:0];
    return r;
  endfunction
endpackage

// File: rtl/esc_tick_gen.sv
module esc_tick_gen #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_q;

  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) div_q <= '0;
        else        div_q <= '0;
    end else begin : g_div
      assign tick = (div_q == LAST);
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end
  endgenerate
endmodule

// File: rtl/esc_wait_timer.sv
module esc_wait_timer #(
  parameter int WAIT_LOAD = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic tick,
  input  logic byte_in,
  output logic expire
);
  localparam int CW = $clog2(WAIT_LOAD + 1);
  localparam logic [CW-1:0] LOAD = CW'(WAIT_LOAD);

  logic [CW-1:0] cnt_q;
  logic [7:0]    rx_cnt_q;
  logic [7:0]    snap_q;
  logic [7:0]    rx_cnt_nx;
  logic          progress;

  assign rx_cnt_nx = rx_cnt_q + 8'(byte_in);
  assign progress  = (rx_cnt_q != snap_q) || byte_in;
  assign expire    = run && tick && !restart && !progress && (cnt_q <= CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      rx_cnt_q <= '0;
      snap_q   <= '0;
    end else begin
      rx_cnt_q <= rx_cnt_nx;
      if (restart) begin
        cnt_q  <= LOAD;
        snap_q <= rx_cnt_nx;
      end else if (run && tick) begin
        if (progress) begin
          cnt_q  <= LOAD;
          snap_q <= rx_cnt_nx;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/esc_pkt_parser.sv
module esc_pkt_parser
  import esc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  output logic        done,
  output logic        sum_ok,
  output logic        started,
  output logic [15:0] opcode,
  output logic [15:0] length
);
  phase_t      phase_q;
  logic [7:0]  sum_q;
  logic [15:0] op_q;
  logic [15:0] len_q;
  logic [15:0] rem_q;
  logic [15:0] len_full;

  assign len_full = {len_q[15:8], byte_in};
  assign done     = byte_vld && (phase_q == PH_CHK);
  assign sum_ok   = (sum8(sum_q, byte_in) == 8'h00);
  assign started  = (phase_q != PH_OPH);
  assign opcode   = op_q;
  assign length   = len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OPH;
      sum_q   <= '0;
      op_q    <= '0;
      len_q   <= '0;
      rem_q   <= '0;
    end else if (clr) begin
      phase_q <= PH_OPH;
      sum_q   <= '0;
      op_q    <= '0;
      len_q   <= '0;
      rem_q   <= '0;
    end else if (byte_vld) begin
      sum_q <= sum8(sum_q, byte_in);
      unique case (phase_q)
        PH_OPH: begin op_q  <= {byte_in, 8'h00};  phase_q <= PH_OPL; end
        PH_OPL: begin op_q[7:0] <= byte_in;       phase_q <= PH_LNH; end
        PH_LNH: begin len_q <= {byte_in, 8'h00};  phase_q <= PH_LNL; end
        PH_LNL: begin
          len_q[7:0] <= byte_in;
          rem_q      <= len_full;
          phase_q    <= (len_full == 16'h0000) ? PH_CHK : PH_PAY;
        end
        PH_PAY: begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == 16'h0001) phase_q <= PH_CHK;
        end
        PH_CHK: begin
          phase_q <= PH_OPH;
          sum_q   <= '0;
        end
        default: phase_q <= PH_OPH;
      endcase
    end
  end
endmodule

// File: rtl/esc_reply_buf.sv
module esc_reply_buf
  import esc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  reply_t     reply,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       busy
);
  reply_t              cur_q;
  logic [REPLY_NW-1:0] idx_q;
  logic                busy_q;

  assign busy     = busy_q;
  assign tx_valid = busy_q;

  always_comb begin
    tx_data = 8'h00;
    for (int i = 0; i < REPLY_MAX; i++)
      if (idx_q == REPLY_NW'(i)) tx_data = cur_q.b[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      cur_q  <= reply;
      idx_q  <= '0;
      busy_q <= (reply.n != '0);
    end else if (busy_q && tx_ready) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == cur_q.n - REPLY_NW'(1)) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/boot_escape_responder.sv
module boot_escape_responder
  import esc_pkg::*;
#(
  parameter int VER_MAJOR   = 1,
  parameter int VER_MINOR   = 0,
  parameter int MAX_PKT_LEN = 256,
  parameter int TICK_DIV    = 1000,
  parameter int WAIT_LOAD   = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic       rx_ready,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic       timed_out
);
  localparam logic [7:0]  MAJ  = 8'(VER_MAJOR);
  localparam logic [7:0]  MNR  = 8'(VER_MINOR);
  localparam logic [15:0] MAXL = 16'(MAX_PKT_LEN);

  sess_t       sess_q;
  logic        to_q;
  logic        reply_busy;
  logic        rx_fire;
  logic        esc_seen;
  logic        data_byte;
  logic        tick;
  logic        expire;
  logic        pkt_done;
  logic        pkt_ok;
  logic        pkt_started;
  logic [15:0] pkt_op;
  logic [15:0] pkt_len;
  logic        rep_load;
  reply_t      rep_next;

  assign rx_ready  = !reply_busy;
  assign rx_fire   = rx_valid && rx_ready;
  assign esc_seen  = rx_fire && (rx_data == BYTE_ESC);
  assign data_byte = rx_fire && !esc_seen && (sess_q == ST_AWAKE);
  assign timed_out = to_q;

  esc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  esc_wait_timer #(.WAIT_LOAD(WAIT_LOAD)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .restart(esc_seen),
    .run((sess_q == ST_AWAKE) && !reply_busy),
    .tick(tick), .byte_in(data_byte), .expire(expire)
  );

  esc_pkt_parser u_parse (
    .clk(clk), .rst_n(rst_n),
    .clr(esc_seen || expire),
    .byte_vld(data_byte), .byte_in(rx_data),
    .done(pkt_done), .sum_ok(pkt_ok), .started(pkt_started),
    .opcode(pkt_op), .length(pkt_len)
  );

  always_comb begin
    rep_load = 1'b0;
    rep_next = '0;
    if (esc_seen) begin
      rep_load = 1'b1;
      rep_next = mk_ack();
    end else if (pkt_done) begin
      rep_load = 1'b1;
      if (pkt_ok && pkt_op == OP_VER && pkt_len <= MAXL)
        rep_next = mk_ver(MAJ, MNR, MAXL);
      else
        rep_next = mk_nak(pkt_op);
    end else if (expire && pkt_started) begin
      rep_load = 1'b1;
      rep_next = mk_nak(pkt_op);
    end
  end

  esc_reply_buf u_reply (
    .clk(clk), .rst_n(rst_n),
    .load(rep_load), .reply(rep_next),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .busy(reply_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sess_q <= ST_ASLEEP;
      to_q   <= 1'b0;
    end else if (esc_seen) begin
      sess_q <= ST_AWAKE;
      to_q   <= 1'b0;
    end else if (expire) begin
      sess_q <= ST_ASLEEP;
      to_q   <= 1'b1;
    end
  end
endmodule

// File: rtl/esc_resp_chk.sv
module esc_resp_chk #(
  parameter int MAX_PKT_LEN = 256
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  rx_data,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        timed_out,
  input logic        pkt_done,
  input logic        pkt_ok,
  input logic [15:0] pkt_op,
  input logic [15:0] pkt_len
);
  // R1
  ack_after_esc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_data == 8'h1B) |=> (tx_valid && tx_data == 8'h06));

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R11
  rx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);

  // R4
  null_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && pkt_ok && pkt_op == 16'h0000) |=> (tx_valid && tx_data == 8'h15));

  // R6
  bad_sum_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !pkt_ok) |=> (tx_valid && tx_data == 8'h15));

  // R5
  ver_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && pkt_ok && pkt_op == 16'h0002 && pkt_len <= 16'(MAX_PKT_LEN))
      |=> (tx_valid && tx_data == 8'h06));

  // R12
  timeout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timed_out) |-> $past(rx_valid && rx_ready && rx_data == 8'h1B));
endmodule

bind boot_escape_responder esc_resp_chk #(.MAX_PKT_LEN(MAX_PKT_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .timed_out(timed_out), .pkt_done(pkt_done),
  .pkt_ok(pkt_ok), .pkt_op(pkt_op), .pkt_len(pkt_len)
);

// File: tb/boot_escape_responder_tb.sv
module boot_escape_responder_tb;
  localparam int MAJ = 3, MNR = 7, MAXL = 64, DIV = 2, WAITL = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready = 1'b1;
  logic       timed_out;

  int checks = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] q[$];

  always #2 clk = ~clk;

  boot_escape_responder #(
    .VER_MAJOR(MAJ), .VER_MINOR(MNR), .MAX_PKT_LEN(MAXL),
    .TICK_DIV(DIV), .WAIT_LOAD(WAITL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .timed_out(timed_out)
  );

  always @(posedge clk) if (rst_n && tx_valid && tx_ready) q.push_back(tx_data);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic expect_q(input string req, input int n, input logic [7:0] e0,
                          input logic [7:0] e1, input logic [7:0] e2,
                          input logic [7:0] e3, input logic [7:0] e4);
    logic [7:0] e[5];
    e = '{e0, e1, e2, e3, e4};
    chk(q.size() == n, req, "reply length", q.size(), n);
    for (int i = 0; i < n; i++)
      if (i < q.size()) chk(q[i] == e[i], req, "reply byte", q[i], e[i]);
    q.delete();
  endtask

  task automatic wake();
    send(8'h1B);
    chk(tx_valid && tx_data == 8'h06, "R1", "ack after escape", tx_data, 8'h06);
    idle(3);
    q.delete();
  endtask

  // Sends a full packet; skipped=1 if a good checksum would collide with 0x1B.
  task automatic send_pkt(input logic [15:0] op, input int len, input bit good,
                          output bit skipped);
    logic [7:0] bytes[$];
    logic [7:0] s, cs, first;
    bytes.push_back(op[15:8]);
    bytes.push_back(op[7:0]);
    bytes.push_back(8'(len >> 8));
    bytes.push_back(8'(len));
    for (int i = 0; i < len; i++) bytes.push_back(8'(8'h20 + i));
    s = 8'h00;
    foreach (bytes[i]) s = s + bytes[i];
    cs = 8'h00 - s;
    skipped = 0;
    if (good && cs == 8'h1B) begin
      skipped = 1;
      return;
    end
    if (!good) begin
      cs = cs ^ 8'h5A;
      if (cs == 8'h1B) cs = cs ^ 8'hA5;
    end
    foreach (bytes[i]) send(bytes[i]);
    send(cs);
    first = (good && op == 16'h0002 && len <= MAXL) ? 8'h06 : 8'h15;
    chk(tx_valid && tx_data == first, "R3", "first reply byte latency", tx_data, first);
  endtask

  task automatic expect_for(input logic [15:0] op, input int len, input bit good);
    if (good && op == 16'h0002 && len <= MAXL)
      expect_q("R5", 5, 8'h06, 8'(MAJ), 8'(MNR), 8'(MAXL >> 8), 8'(MAXL));
    else if (!good)
      expect_q("R6", 3, 8'h15, op[15:8], op[7:0], 8'h00, 8'h00);
    else if (op == 16'h0000)
      expect_q("R4", 3, 8'h15, 8'h00, 8'h00, 8'h00, 8'h00);
    else
      expect_q("R7", 3, 8'h15, op[15:8], op[7:0], 8'h00, 8'h00);
  endtask

  initial begin
    bit sk;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R13 reset state
    chk(!tx_valid, "R13", "tx_valid after reset", tx_valid, 0);
    chk(rx_ready, "R13", "rx_ready after reset", rx_ready, 1);
    chk(!timed_out, "R13", "timed_out after reset", timed_out, 0);

    // R2 asleep: a valid version packet is dropped
    send(8'h00); send(8'h02); send(8'h00); send(8'h00); send(8'hFE);
    idle(6);
    chk(q.size() == 0 && !tx_valid, "R2", "no reply while asleep", q.size(), 0);

    // R1 single and burst
    wake();
    for (int i = 0; i < 16; i++) send(8'h1B);
    idle(4);
    chk(q.size() == 16, "R1", "ack burst count", q.size(), 16);
    foreach (q[i]) chk(q[i] == 8'h06, "R1", "burst byte", q[i], 8'h06);
    q.delete();

    // R3..R7 sweep over opcodes, lengths, checksum quality
    for (int op = 0; op < 5; op++)
      for (int len = 0; len < 4; len++)
        for (int g = 0; g < 2; g++) begin
          send_pkt(16'(op), len, g[0], sk);
          idle(8);
          if (!sk) expect_for(16'(op), len, g[0]);
        end

    // R7 large opcode and oversized version request
    send_pkt(16'hA5C3, 1, 1'b1, sk);
    idle(8);
    if (!sk) expect_for(16'hA5C3, 1, 1'b1);
    send_pkt(16'h0002, MAXL + 1, 1'b1, sk);
    idle(8);
    if (!sk) expect_for(16'h0002, MAXL + 1, 1'b1);
    send_pkt(16'h0002, MAXL, 1'b1, sk);
    idle(8);
    if (!sk) expect_for(16'h0002, MAXL, 1'b1);

    // R8 escape mid-packet
    send(8'h00); send(8'h02); send(8'h00);
    send(8'h1B);
    chk(tx_valid && tx_data == 8'h06, "R8", "ack on mid-packet escape", tx_data, 8'h06);
    idle(4);
    expect_q("R8", 1, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00);
    send_pkt(16'h0002, 0, 1'b1, sk);
    idle(8);
    expect_for(16'h0002, 0, 1'b1);

    // R11 backpressure
    @(negedge clk);
    tx_ready = 1'b0;
    send_pkt(16'h0002, 0, 1'b1, sk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(tx_valid && tx_data == 8'h06, "R11", "held reply byte", tx_data, 8'h06);
      chk(!rx_ready, "R11", "rx_ready during reply", rx_ready, 0);
    end
    tx_ready = 1'b1;
    idle(8);
    expect_for(16'h0002, 0, 1'b1);

    // R9 slow bytes keep the session alive
    wake();
    send(8'h00); idle(300);
    send(8'h02); idle(300);
    send(8'h00); send(8'h00); send(8'hFE);
    idle(8);
    chk(!timed_out, "R9", "no timeout with progress", timed_out, 0);
    expect_for(16'h0002, 0, 1'b1);

    // R9 timeout with no packet
    wake();
    idle(370);
    chk(!timed_out, "R9", "timed_out early", timed_out, 0);
    idle(60);
    chk(timed_out, "R9", "timed_out after wait", timed_out, 1);
    chk(q.size() == 0, "R9", "silent timeout", q.size(), 0);
    // R2 after timeout, R12 flag holds
    send(8'h00); send(8'h02); send(8'h00); send(8'h00); send(8'hFE);
    idle(6);
    chk(q.size() == 0, "R2", "no reply after timeout", q.size(), 0);
    chk(timed_out, "R12", "flag held until escape", timed_out, 1);
    send(8'h1B);
    chk(!timed_out, "R12", "flag cleared by escape", timed_out, 0);
    idle(4);
    q.delete();

    // R10 partial packet timeout, full opcode
    send(8'h00); send(8'h02);
    idle(375);
    chk(!timed_out, "R10", "partial timeout early", timed_out, 0);
    idle(60);
    chk(timed_out, "R10", "partial timeout", timed_out, 1);
    expect_q("R10", 3, 8'h15, 8'h00, 8'h02, 8'h00, 8'h00);

    // R10 partial packet timeout, half opcode
    wake();
    send(8'h05);
    idle(440);
    chk(timed_out, "R10", "half opcode timeout", timed_out, 1);
    expect_q("R10", 3, 8'h15, 8'h05, 8'h00, 8'h00, 8'h00);

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule